// File: doc/BRIEF.md
# Tenths-Resolution Stopwatch Timing Core

This block keeps elapsed time for a stopwatch with a resolution of one tenth of a second and a span from 00:00.0 to 59:59.9. The time is held as five BCD digits: tenths, seconds units, seconds tens, minutes units and minutes tens. A single-cycle tick enable marks each tenth of a second. A start/stop pulse toggles the core between counting and holding. An asynchronous reset returns every digit to zero and leaves the watch stopped.

The digits form a mixed-radix cascade. The tenths digit, the seconds units and the minutes units count modulo ten. The two tens digits count modulo six. A stage advances when every less significant stage sits at its maximum on a counted tick. The carries are combinational, so all digits that change on a tick change on the same clock edge. After 59:59.9 the count wraps to 00:00.0 and keeps running.

A neighbouring block supplies the tick, the debounced button pulse and the seven-segment display path.

Top module: `stopwatch_core`

## Requirements
- R1: While running, each cycle with `tick` high advances `tenths` by one, and it wraps from 9 to 0. The digit holds a plain BCD value (0 to 9).
- R2: `sec_ones` and `min_ones` each count modulo 10 and never leave the range 0 to 9.
- R3: `sec_tens` and `min_tens` each count modulo 6 and never leave the range 0 to 5.
- R4: A digit advances on a counted tick only when every less significant digit is at its maximum (9, or 5 for a tens digit). Every digit that changes on that tick changes on the same clock edge. When this condition is not met, the digit is unchanged.
- R5: A counted tick at 59:59.9 gives 00:00.0 on the next edge, and counting continues.
- R6: A cycle with `start_stop` high inverts `running` at the next clock edge. The tick in that same cycle counts according to the value `running` had before the edge.
- R7: While `running` is low, every digit holds its value whatever `tick` does.
- R8: While `arst` is high, all five digits and `running` are zero, asynchronously and regardless of state. After reset the watch stays stopped until a `start_stop` pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst | input | 1 | Asynchronous reset, active high |
| tick | input | 1 | Single-cycle tenth-of-a-second enable |
| start_stop | input | 1 | Single-cycle start/stop toggle pulse |
| tenths | output | 4 | Tenths of a second, BCD |
| sec_ones | output | 4 | Seconds units, BCD |
| sec_tens | output | 4 | Seconds tens, 0 to 5 |
| min_ones | output | 4 | Minutes units, BCD |
| min_tens | output | 4 | Minutes tens, 0 to 5 |
| running | output | 1 | High while the watch counts |

## Verification
The assertions check on every cycle that each digit stays in its range and that a held watch keeps its digits. They also check the tenths increment, the seconds-units carry and its absence, the toggle of `running`, the full wrap and the reset state. The bench's reference model covers the behaviour that only long scenarios reach. This includes carries into the minutes digits after thousands of ticks, gaps of several cycles between ticks, a press that coincides with a tick, and a reset applied in the middle of a run.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
   // Number of digit stages in the timing cascade, least significant first.
   localparam int unsigned SW_STAGES = 5;

   // Modulus of stage i: tenths, sec units, sec tens, min units, min tens.
   function automatic int unsigned stage_modulus(input int unsigned idx);
      return ((idx == 2) || (idx == 4)) ? 6 : 10;
   endfunction

   // Width needed to hold the largest digit of the cascade.
   function automatic int unsigned min_digit_width();
      return 4;
   endfunction
endpackage

// File: rtl/sw_run_toggle.sv
module sw_run_toggle (
   input  logic clk,
   input  logic arst,
   input  logic press,
   output logic run_q
);
   always_ff @(posedge clk or posedge arst) begin
      if (arst)
         run_q <= 1'b0;
      else if (press)
         run_q <= ~run_q;
   end
endmodule

// File: rtl/sw_digit_stage.sv
module sw_digit_stage #(
   parameter int unsigned DIGIT_W = 4,
   parameter int unsigned MODULUS = 10
) (
   input  logic               clk,
   input  logic               arst,
   input  logic               adv,
   output logic [DIGIT_W-1:0] digit,
   output logic               carry
);
   localparam logic [DIGIT_W-1:0] TOP_VAL = DIGIT_W'(MODULUS - 1);

   if (MODULUS < 2 || MODULUS > (1 << DIGIT_W)) begin : g_bad_mod
      $error("sw_digit_stage: MODULUS does not fit DIGIT_W");
   end

   logic at_top;
   assign at_top = (digit == TOP_VAL);
   assign carry  = adv & at_top;

   always_ff @(posedge clk or posedge arst) begin
      if (arst)
         digit <= '0;
      else if (adv)
         digit <= at_top ? '0 : digit + DIGIT_W'(1);
   end
endmodule

// File: rtl/stopwatch_core.sv
module stopwatch_core
   import stopwatch_pkg::*;
#(
   parameter int unsigned DIGIT_W = 4
) (
   input  logic               clk,
   input  logic               arst,
   input  logic               tick,
   input  logic               start_stop,
   output logic [DIGIT_W-1:0] tenths,
   output logic [DIGIT_W-1:0] sec_ones,
   output logic [DIGIT_W-1:0] sec_tens,
   output logic [DIGIT_W-1:0] min_ones,
   output logic [DIGIT_W-1:0] min_tens,
   output logic               running
);
   localparam int unsigned N = SW_STAGES;

   if (DIGIT_W < min_digit_width()) begin : g_bad_width
      $error("stopwatch_core: DIGIT_W too small for BCD digits");
   end

   logic [N:0]         adv_chain;
   logic [DIGIT_W-1:0] digits [N];

   sw_run_toggle u_run (
      .clk   (clk),
      .arst  (arst),
      .press (start_stop),
      .run_q (running)
   );

   assign adv_chain[0] = running & tick;

   for (genvar i = 0; i < N; i++) begin : g_stage
      sw_digit_stage #(
         .DIGIT_W (DIGIT_W),
         .MODULUS (stage_modulus(i))
      ) u_stage (
         .clk   (clk),
         .arst  (arst),
         .adv   (adv_chain[i]),
         .digit (digits[i]),
         .carry (adv_chain[i+1])
      );
   end

   assign tenths   = digits[0];
   assign sec_ones = digits[1];
   assign sec_tens = digits[2];
   assign min_ones = digits[3];
   assign min_tens = digits[4];
endmodule

// File: rtl/stopwatch_core_chk.sv
module stopwatch_core_chk #(
   parameter int unsigned DIGIT_W = 4
) (
   input logic               clk,
   input logic               arst,
   input logic               tick,
   input logic               start_stop,
   input logic [DIGIT_W-1:0] tenths,
   input logic [DIGIT_W-1:0] sec_ones,
   input logic [DIGIT_W-1:0] sec_tens,
   input logic [DIGIT_W-1:0] min_ones,
   input logic [DIGIT_W-1:0] min_tens,
   input logic               running
);
   logic counted, all_top;
   assign counted = running & tick;
   assign all_top = (tenths == 9) && (sec_ones == 9) && (sec_tens == 5) &&
                    (min_ones == 9) && (min_tens == 5);

   a_r1_tenths_range: assert property (@(posedge clk) disable iff (arst)
      tenths <= DIGIT_W'(9));
   a_r2_units_range: assert property (@(posedge clk) disable iff (arst)
      (sec_ones <= DIGIT_W'(9)) && (min_ones <= DIGIT_W'(9)));
   a_r3_tens_range: assert property (@(posedge clk) disable iff (arst)
      (sec_tens <= DIGIT_W'(5)) && (min_tens <= DIGIT_W'(5)));
   a_r1_tenths_step: assert property (@(posedge clk) disable iff (arst)
      counted |=> tenths == (($past(tenths) == DIGIT_W'(9)) ? '0 : $past(tenths) + DIGIT_W'(1)));
   a_r4_carry_step: assert property (@(posedge clk) disable iff (arst)
      (counted && tenths == 9 && sec_ones != 9) |=> sec_ones == $past(sec_ones) + DIGIT_W'(1));
   a_r4_no_carry: assert property (@(posedge clk) disable iff (arst)
      (counted && tenths != 9) |=> $stable(sec_ones) && $stable(sec_tens) &&
                                   $stable(min_ones) && $stable(min_tens));
   a_r5_wrap: assert property (@(posedge clk) disable iff (arst)
      (counted && all_top) |=> (tenths == 0) && (sec_ones == 0) && (sec_tens == 0) &&
                               (min_ones == 0) && (min_tens == 0));
   a_r6_toggle: assert property (@(posedge clk) disable iff (arst)
      start_stop |=> running != $past(running));
   a_r6_steady: assert property (@(posedge clk) disable iff (arst)
      !start_stop |=> $stable(running));
   a_r7_hold: assert property (@(posedge clk) disable iff (arst)
      !running |=> $stable(tenths) && $stable(sec_ones) && $stable(sec_tens) &&
                   $stable(min_ones) && $stable(min_tens));

   always @(negedge clk) begin
      if (arst) begin
         a_r8_reset_state: assert ((tenths | sec_ones | sec_tens | min_ones | min_tens) == '0
                                   && !running);
      end
   end
endmodule

bind stopwatch_core stopwatch_core_chk #(.DIGIT_W(DIGIT_W)) u_chk (.*);

// File: tb/stopwatch_core_bench.sv
`timescale 1ns/1ps
module stopwatch_core_bench;
   logic clk = 1'b0;
   logic arst = 1'b1;
   logic tick = 1'b0;
   logic start_stop = 1'b0;
   logic [3:0] tenths, sec_ones, sec_tens, min_ones, min_tens;
   logic running;

   int errors = 0;
   int checks = 0;
   int ref_cnt = 0;
   bit ref_run = 0;
   bit done = 0;

   always #4 clk = ~clk;

   stopwatch_core u_stopwatch_core (
      .clk(clk), .arst(arst), .tick(tick), .start_stop(start_stop),
      .tenths(tenths), .sec_ones(sec_ones), .sec_tens(sec_tens),
      .min_ones(min_ones), .min_tens(min_tens), .running(running)
   );

   // Behavioural reference: total tenths elapsed plus a run flag.
   always @(posedge clk or posedge arst) begin
      if (arst) begin
         ref_cnt = 0;
         ref_run = 0;
      end else begin
         if (ref_run && tick) ref_cnt = (ref_cnt + 1) % 36000;
         if (start_stop) ref_run = !ref_run;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string tag);
      chk({tag, " R1 tenths"},   tenths,   ref_cnt % 10);
      chk({tag, " R2 sec_ones"}, sec_ones, (ref_cnt / 10) % 10);
      chk({tag, " R3 sec_tens"}, sec_tens, ((ref_cnt / 10) % 60) / 10);
      chk({tag, " R2 min_ones"}, min_ones, (ref_cnt / 600) % 10);
      chk({tag, " R3 min_tens"}, min_tens, ref_cnt / 6000);
      chk({tag, " R6 running"},  running,  ref_run);
   endtask

   // Compare against the model on every cycle, away from the active edge.
   always @(negedge clk) if (!arst && !done) compare_all("cycle");

   task automatic step(input bit t, input bit p);
      @(negedge clk); #1;
      tick = t; start_stop = p;
   endtask

   task automatic run_ticks(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         step(1'b1, 1'b0);
         for (int g = 0; g < gap; g++) step(1'b0, 1'b0);
      end
      step(1'b0, 1'b0);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #1;
      chk("R8 reset digits", {tenths, sec_ones, sec_tens, min_ones, min_tens}, 0);
      chk("R8 reset running", running, 0);
      @(negedge clk); #1 arst = 1'b0;
      // R8: stays stopped without a press; ticks ignored
      run_ticks(5, 0);
      chk("R8 idle after reset", tenths, 0);
      // R6: press starts
      step(1'b0, 1'b1); step(1'b0, 1'b0);
      chk("R6 started", running, 1);
      // R1 / R4: tick every cycle, carry into seconds
      run_ticks(12, 0);
      chk("R4 carry to sec_ones", {sec_ones, tenths}, {4'd1, 4'd2});
      // sparse ticks
      run_ticks(7, 2);
      // R6: press together with tick while running: tick counts
      step(1'b1, 1'b1); step(1'b0, 1'b0);
      chk("R6 stop running", running, 0);
      chk("R6 tick with press counted", tenths, 0);
      // R7: hold while stopped
      run_ticks(20, 0);
      chk("R7 held tenths", tenths, 0);
      chk("R7 held sec_ones", sec_ones, 2);
      // R6: press with tick while stopped: tick not counted
      step(1'b1, 1'b1); step(1'b0, 1'b0);
      chk("R6 restart tick ignored", tenths, 0);
      // R2/R3/R5: run to the full wrap (the watch now shows 2.0 s)
      run_ticks(35999 - 20, 0);
      chk("R5 at max min_tens", min_tens, 5);
      chk("R5 at max tenths", tenths, 9);
      run_ticks(1, 0);
      chk("R5 wrapped", {min_tens, min_ones, sec_tens, sec_ones, tenths}, 0);
      chk("R5 keeps running", running, 1);
      run_ticks(3, 0);
      chk("R5 counting after wrap", tenths, 3);
      // R8: asynchronous reset mid-run
      run_ticks(650, 0);
      @(negedge clk); #2 arst = 1'b1;
      #1;
      chk("R8 async clear digits", {min_tens, min_ones, sec_tens, sec_ones, tenths}, 0);
      chk("R8 async clear running", running, 0);
      @(negedge clk); #1 arst = 1'b0;
      run_ticks(4, 0);
      chk("R8 stopped after reset", tenths, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule